// File: doc/BRIEF.md
# Quad Power-Rail Enable Sequencer

This block turns four power-rail enables on in a fixed order once a monitored supply is inside its voltage window. It turns them off again in the opposite order. The supply window arrives as two digitised flags: one says the supply is above its low limit and one says it is below its high limit. A level input gates sequencing. Every wait is counted in ticks of a tick-enable input. A single restartable interval counter times each wait, so one counter serves the start delay and all three stage gaps in both directions.

A fault flag reports that the supply has stayed outside its window longer than a programmed filter time. Shorter excursions do not set the flag. When sequencing is cut off, or a filtered fault occurs, the enables go down one stage at a time, starting from the highest stage currently on. A build-time option removes the sequence-enable control. In that variant all enables drop together on a fault. A second option makes the enables active-low.

Top module: `rail_seq_top`

## Requirements
- R1: While `rst` is high, and after it is released with no other stimulus, all four enables are inactive and `fault` is 0.
- R2: `railEn[0]` is A, `railEn[1]` is B, `railEn[2]` is C and `railEn[3]` is D. During power-up they turn on strictly in the order A, B, C, D. Each next stage turns on on the (gap+1)-th tick after the previous stage turned on. `gapAb` sets the A to B wait, `gapBc` sets the B to C wait and `gapCd` sets the C to D wait.
- R3: Power-up starts on the first clock at which `uvOk`, `ovOk` and `seqEn` are all 1 and `fault` is 0. Enable A turns on on the (startDly+1)-th tick after that clock.
- R4: If either window flag drops while the start delay is running, the block goes back to idle. A later start then waits a full, uninterrupted start delay.
- R5: Clocks with `tick` low do not advance any delay.
- R6: On a falling `seqEn` with all stages on, D turns off on the next clock. C then turns off after `gapCd`+1 ticks, B after a further `gapBc`+1 ticks, and A after a further `gapAb`+1 ticks.
- R7: If `seqEn` falls part-way through power-up, the highest stage that is on turns off on the next clock. The remaining stages then turn off in reverse order, using the same gaps as in R6.
- R8: `fault` rises after `faultDly`+1 consecutive ticks with `uvOk` or `ovOk` low. A shorter excursion leaves `fault` at 0. `fault` clears on the first clock at which both flags are 1.
- R9: With sequence-enable present, a rising `fault` starts the reverse power-down on the following clock, exactly as a falling `seqEn` does.
- R10: With `ACTIVE_LOW`=1, each enable output reads 0 when its stage is on and 1 when it is off.
- R11: With `HAS_SEQ_EN`=0, `seqEn` has no effect. All stages that are on turn off together on the clock after `fault` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Enables one count step of every delay |
| uvOk | input | 1 | Supply is above its low limit |
| ovOk | input | 1 | Supply is below its high limit |
| seqEn | input | 1 | Sequence-enable level (ignored when HAS_SEQ_EN=0) |
| startDly | input | CNT_W | Ticks from compliance to enable A, minus one |
| gapAb | input | CNT_W | Gap between A and B, used in both directions |
| gapBc | input | CNT_W | Gap between B and C, used in both directions |
| gapCd | input | CNT_W | Gap between C and D, used in both directions |
| faultDly | input | FILT_W | Excursion filter length in ticks, minus one |
| railEn | output | 4 | Stage enables A..D (bit 0 = A), polarity per ACTIVE_LOW |
| fault | output | 1 | Filtered out-of-window flag |

## Verification
The bench schedules every expected enable and fault change at an exact cycle and compares each change as it happens. This exposes an off-by-one in the gap counting or a stage that moves a cycle early or late. A one-clock window dropout during the start delay checks that the timer restarts from zero. A design that only paused the timer would bring up A early. Stretches of `tick` low during a gap must push B back by exactly that many cycles. A three-tick excursion with a three-tick filter must leave everything unchanged. One tick more must raise `fault` and start the reverse power-down. A second instance with the opposite options checks the inverted polarity, that `seqEn` is ignored, and that all enables drop in the same clock on a fault.

// File: rtl/seq_pkg.sv
package seq_pkg;
  localparam int N_RAIL = 4;
  localparam int LVL_W  = $clog2(N_RAIL + 1);

  typedef enum logic [1:0] {
    DSEL_START,
    DSEL_AB,
    DSEL_BC,
    DSEL_CD
  } dlySel_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_UP,
    ST_ON,
    ST_DOWN
  } seqState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic    restart;
    dlySel_e sel;
  } cntCmd_t;

  // status from datapath to control
  typedef struct packed {
    logic expired;
    logic fault;
    logic inWin;
  } dpStat_t;
endpackage

// File: rtl/seq_dpath.sv
module seq_dpath
  import seq_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int FILT_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              uvOk,
  input  logic              ovOk,
  input  logic [CNT_W-1:0]  startDly,
  input  logic [CNT_W-1:0]  gapAb,
  input  logic [CNT_W-1:0]  gapBc,
  input  logic [CNT_W-1:0]  gapCd,
  input  logic [FILT_W-1:0] faultDly,
  input  cntCmd_t           cmd,
  output dpStat_t           stat
);
  logic [CNT_W-1:0]  cnt;
  logic [CNT_W-1:0]  tgt;
  logic [CNT_W-1:0]  dlyPick;
  logic [FILT_W-1:0] filtCnt;
  logic              faultQ;
  logic              inWin;

  assign inWin = uvOk & ovOk;

  always_comb begin
    case (cmd.sel)
      DSEL_START: dlyPick = startDly;
      DSEL_AB:    dlyPick = gapAb;
      DSEL_BC:    dlyPick = gapBc;
      default:    dlyPick = gapCd;
    endcase
  end

  // one restartable interval counter; target latched at interval start
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      tgt <= '0;
    end else if (cmd.restart) begin
      cnt <= '0;
      tgt <= dlyPick;
    end else if (tick && (cnt != tgt)) begin
      cnt <= cnt + CNT_W'(1);
    end
  end

  // excursion filter
  always_ff @(posedge clk) begin
    if (rst) begin
      filtCnt <= '0;
      faultQ  <= 1'b0;
    end else if (inWin) begin
      filtCnt <= '0;
      faultQ  <= 1'b0;
    end else if (tick && !faultQ) begin
      if (filtCnt == faultDly) faultQ <= 1'b1;
      else                     filtCnt <= filtCnt + FILT_W'(1);
    end
  end

  assign stat.expired = tick && (cnt == tgt);
  assign stat.fault   = faultQ;
  assign stat.inWin   = inWin;

  AST_TICK_GATE: assert property (@(posedge clk) disable iff (rst)
    (!tick && !cmd.restart) |=> $stable(cnt)); // R5
  AST_FAULT_FILTERED: assert property (@(posedge clk) disable iff (rst)
    $rose(faultQ) |-> $past(!inWin)); // R8
  AST_FAULT_CLEAR: assert property (@(posedge clk) disable iff (rst)
    inWin |=> !faultQ); // R8
endmodule

// File: rtl/seq_ctrl.sv
module seq_ctrl
  import seq_pkg::*;
#(
  parameter bit HAS_SEQ_EN = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             seqEn,
  input  dpStat_t          stat,
  output cntCmd_t          cmd,
  output logic [LVL_W-1:0] lvl
);
  localparam logic [LVL_W-1:0] LVL_TOP = LVL_W'(N_RAIL);

  seqState_e        state, stateN;
  logic [LVL_W-1:0] lvlN;
  logic             seqOk;
  logic             abort;
  logic             go;

  generate
    if (HAS_SEQ_EN) begin : g_seq
      assign seqOk = seqEn;
    end else begin : g_noseq
      assign seqOk = 1'b1;
    end
  endgenerate

  assign abort = !seqOk || stat.fault;
  assign go    = stat.inWin && seqOk && !stat.fault;

  // gap that separates stage l from stage l+1
  function automatic dlySel_e gapSel(input logic [LVL_W-1:0] l);
    case (l)
      LVL_W'(1): gapSel = DSEL_AB;
      LVL_W'(2): gapSel = DSEL_BC;
      default:   gapSel = DSEL_CD;
    endcase
  endfunction

  always_comb begin
    stateN      = state;
    lvlN        = lvl;
    cmd.restart = 1'b0;
    cmd.sel     = DSEL_START;
    case (state)
      ST_IDLE: begin
        if (go) begin
          stateN      = ST_START;
          cmd.restart = 1'b1;
        end
      end
      ST_START: begin
        if (!go) begin
          stateN = ST_IDLE;
        end else if (stat.expired) begin
          lvlN        = LVL_W'(1);
          stateN      = ST_UP;
          cmd.restart = 1'b1;
          cmd.sel     = DSEL_AB;
        end
      end
      ST_UP, ST_ON: begin
        if (abort) begin
          if (!HAS_SEQ_EN) begin
            lvlN   = '0;
            stateN = ST_IDLE;
          end else begin
            lvlN = lvl - LVL_W'(1);
            if (lvlN == '0) begin
              stateN = ST_IDLE;
            end else begin
              stateN      = ST_DOWN;
              cmd.restart = 1'b1;
              cmd.sel     = gapSel(lvlN);
            end
          end
        end else if (state == ST_UP && stat.expired) begin
          lvlN = lvl + LVL_W'(1);
          if (lvlN == LVL_TOP) begin
            stateN = ST_ON;
          end else begin
            cmd.restart = 1'b1;
            cmd.sel     = gapSel(lvlN);
          end
        end
      end
      ST_DOWN: begin
        if (stat.expired) begin
          lvlN = lvl - LVL_W'(1);
          if (lvlN == '0) begin
            stateN = ST_IDLE;
          end else begin
            cmd.restart = 1'b1;
            cmd.sel     = gapSel(lvlN);
          end
        end
      end
      default: begin
        stateN = ST_IDLE;
        lvlN   = '0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      lvl   <= '0;
    end else begin
      state <= stateN;
      lvl   <= lvlN;
    end
  end

  AST_RISE_NEEDS_OK: assert property (@(posedge clk) disable iff (rst)
    (lvl > $past(lvl)) |-> $past(seqOk && !stat.fault)); // R3
  AST_LVL_BOUND: assert property (@(posedge clk) disable iff (rst)
    lvl <= LVL_TOP); // R2

  generate
    if (HAS_SEQ_EN) begin : g_stepChk
      AST_ONE_STEP: assert property (@(posedge clk) disable iff (rst)
        (lvl != $past(lvl)) |->
          ((lvl == $past(lvl) + LVL_W'(1)) || (lvl == $past(lvl) - LVL_W'(1)))); // R6
    end else begin : g_latchChk
      AST_LATCH_OFF: assert property (@(posedge clk) disable iff (rst)
        (stat.fault && lvl != '0) |=> (lvl == '0)); // R11
    end
  endgenerate
endmodule

// File: rtl/rail_seq_top.sv
module rail_seq_top
  import seq_pkg::*;
#(
  parameter int CNT_W      = 16,
  parameter int FILT_W     = 8,
  parameter bit ACTIVE_LOW = 1'b0,
  parameter bit HAS_SEQ_EN = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              uvOk,
  input  logic              ovOk,
  input  logic              seqEn,
  input  logic [CNT_W-1:0]  startDly,
  input  logic [CNT_W-1:0]  gapAb,
  input  logic [CNT_W-1:0]  gapBc,
  input  logic [CNT_W-1:0]  gapCd,
  input  logic [FILT_W-1:0] faultDly,
  output logic [3:0]        railEn,
  output logic              fault
);
  cntCmd_t          cmd;
  dpStat_t          stat;
  logic [LVL_W-1:0] lvl;

  seq_dpath #(.CNT_W(CNT_W), .FILT_W(FILT_W)) u_dpath (
    .clk(clk), .rst(rst), .tick(tick), .uvOk(uvOk), .ovOk(ovOk),
    .startDly(startDly), .gapAb(gapAb), .gapBc(gapBc), .gapCd(gapCd),
    .faultDly(faultDly), .cmd(cmd), .stat(stat)
  );

  seq_ctrl #(.HAS_SEQ_EN(HAS_SEQ_EN)) u_ctrl (
    .clk(clk), .rst(rst), .seqEn(seqEn), .stat(stat), .cmd(cmd), .lvl(lvl)
  );

  // thermometer decode of the stage level, then polarity
  generate
    for (genvar i = 0; i < N_RAIL; i++) begin : g_rail
      assign railEn[i] = (lvl > LVL_W'(i)) ^ ACTIVE_LOW;
    end
  endgenerate

  assign fault = stat.fault;
endmodule

// File: tb/sim_rail_seq_top.sv
`timescale 1ns/1ps
module sim_rail_seq_top;
  localparam int S  = 10;
  localparam int GA = 4;
  localparam int GB = 7;
  localparam int GC = 2;
  localparam int F  = 3;

  logic clk = 1'b0;
  logic rst, tick, uvOk, ovOk, seqEn;
  logic [15:0] startDly, gapAb, gapBc, gapCd;
  logic [7:0]  faultDly;
  logic [3:0]  en0, en1;
  logic        flt0, flt1;
  int cyc = 0;
  int nChk = 0;
  int nFail = 0;
  bit done = 1'b0;

  typedef struct { int c; logic [4:0] v; } evt_t;
  evt_t  evQ[$];
  string tagQ[$];
  logic [4:0] prev;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  rail_seq_top #(.ACTIVE_LOW(1'b0), .HAS_SEQ_EN(1'b1)) u0 (
    .clk(clk), .rst(rst), .tick(tick), .uvOk(uvOk), .ovOk(ovOk), .seqEn(seqEn),
    .startDly(startDly), .gapAb(gapAb), .gapBc(gapBc), .gapCd(gapCd),
    .faultDly(faultDly), .railEn(en0), .fault(flt0));

  rail_seq_top #(.ACTIVE_LOW(1'b1), .HAS_SEQ_EN(1'b0)) u1 (
    .clk(clk), .rst(rst), .tick(tick), .uvOk(uvOk), .ovOk(ovOk), .seqEn(seqEn),
    .startDly(startDly), .gapAb(gapAb), .gapBc(gapBc), .gapCd(gapCd),
    .faultDly(faultDly), .railEn(en1), .fault(flt1));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic push(input int c, input logic [3:0] e, input logic f, input string t);
    evt_t x;
    x.c = c;
    x.v = {e, f};
    evQ.push_back(x);
    tagQ.push_back(t);
  endtask

  task automatic waitTo(input int n);
    while (cyc < n) @(negedge clk);
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  endtask

  // monitor: every change of {enables, fault} on u0 must match the next scheduled event
  always @(negedge clk) begin
    if (rst) begin
      prev <= 5'b0;
    end else if ({en0, flt0} != prev) begin
      prev <= {en0, flt0};
      if (evQ.size() == 0) begin
        chk(1'b0, "unexpected-change", {en0, flt0}, prev);
      end else begin
        evt_t  x;
        string t;
        x = evQ.pop_front();
        t = tagQ.pop_front();
        chk(x.c == cyc, {t, " cycle"}, cyc, x.c);
        chk(x.v == {en0, flt0}, {t, " value"}, {en0, flt0}, x.v);
      end
    end
  end

  always @(posedge clk) begin
    if (cyc > 20000 && !done) begin
      chk(1'b0, "watchdog", cyc, 20000);
      finishRun();
    end
  end

  initial begin
    int c, r, t, tS, tA, tB, tC, tD, tf;
    rst = 1'b1; tick = 1'b1; uvOk = 1'b0; ovOk = 1'b0; seqEn = 1'b0;
    startDly = 16'(S); gapAb = 16'(GA); gapBc = 16'(GB); gapCd = 16'(GC);
    faultDly = 8'(F);
    repeat (3) @(negedge clk);
    chk(en0 == 4'h0, "R1 u0 enables in reset", en0, 0);
    chk(flt0 == 1'b0, "R1 fault in reset", flt0, 0);
    chk(en1 == 4'hF, "R10 active-low idle", en1, 4'hF);
    rst = 1'b0;
    r = cyc;
    push(r + 1 + F, 4'b0000, 1'b1, "R8 fault from idle");
    seqEn = 1'b1;
    waitTo(r + F + 6);
    c = cyc; uvOk = 1'b1; ovOk = 1'b1;
    push(c + 1, 4'b0000, 1'b0, "R8 fault clear");
    tS = c + 2;
    // one-clock dropout during the start delay: timer must restart
    waitTo(tS + 3);
    uvOk = 1'b0;
    @(negedge clk);
    uvOk = 1'b1;
    r = cyc;
    tS = r + 1;
    tA = tS + 1 + S;
    push(tA, 4'b0001, 1'b0, "R4 restart then A");
    waitTo(tA);
    tick = 1'b0;
    repeat (5) @(negedge clk);
    tick = 1'b1;
    tB = tA + 1 + GA + 5;
    push(tB, 4'b0011, 1'b0, "R5 tick-gated B");
    tC = tB + 1 + GB; push(tC, 4'b0111, 1'b0, "R2 C");
    tD = tC + 1 + GC; push(tD, 4'b1111, 1'b0, "R2 D");
    waitTo(tD + 3);
    chk(en0 == 4'hF, "R2 all on", en0, 4'hF);
    chk(en1 == 4'h0, "R10 active-low all on", en1, 0);
    // short excursion: exactly faultDly ticks, must be ignored
    ovOk = 1'b0;
    repeat (F) @(negedge clk);
    ovOk = 1'b1;
    repeat (20) @(negedge clk);
    chk(flt0 == 1'b0, "R8 short excursion ignored", flt0, 0);
    chk(en0 == 4'hF, "R8 enables kept", en0, 4'hF);
    // reverse power-down on seqEn
    c = cyc; seqEn = 1'b0;
    t = c + 1;      push(t, 4'b0111, 1'b0, "R6 D off");
    t = t + 1 + GC; push(t, 4'b0011, 1'b0, "R6 C off");
    t = t + 1 + GB; push(t, 4'b0001, 1'b0, "R6 B off");
    t = t + 1 + GA; push(t, 4'b0000, 1'b0, "R6 A off");
    waitTo(t + 3);
    chk(en1 == 4'h0, "R11 seqEn ignored", en1, 0);
    // abort part-way through power-up
    c = cyc; seqEn = 1'b1;
    tA = c + 2 + S; push(tA, 4'b0001, 1'b0, "R3 start delay");
    tB = tA + 1 + GA; push(tB, 4'b0011, 1'b0, "R2 B");
    waitTo(tB);
    seqEn = 1'b0;
    t = tB + 1;     push(t, 4'b0001, 1'b0, "R7 B off first");
    t = t + 1 + GA; push(t, 4'b0000, 1'b0, "R7 A off");
    waitTo(t + 3);
    // full power-up, then a filtered fault
    c = cyc; seqEn = 1'b1;
    tA = c + 2 + S;   push(tA, 4'b0001, 1'b0, "R2 A");
    tB = tA + 1 + GA; push(tB, 4'b0011, 1'b0, "R2 B");
    tC = tB + 1 + GB; push(tC, 4'b0111, 1'b0, "R2 C");
    tD = tC + 1 + GC; push(tD, 4'b1111, 1'b0, "R2 D");
    waitTo(tD + 2);
    c = cyc; uvOk = 1'b0;
    tf = c + 1 + F;   push(tf, 4'b1111, 1'b1, "R8 fault rise");
    t = tf + 1;       push(t, 4'b0111, 1'b1, "R9 D off");
    t = t + 1 + GC;   push(t, 4'b0011, 1'b1, "R9 C off");
    t = t + 1 + GB;   push(t, 4'b0001, 1'b1, "R9 B off");
    t = t + 1 + GA;   push(t, 4'b0000, 1'b1, "R9 A off");
    waitTo(tf);
    chk(en1 == 4'h0, "R11 still on at fault", en1, 0);
    waitTo(tf + 1);
    chk(en1 == 4'hF, "R11 latch-off", en1, 4'hF);
    waitTo(t + 2);
    c = cyc; seqEn = 1'b0; uvOk = 1'b1;
    push(c + 1, 4'b0000, 1'b0, "R8 clear on return");
    waitTo(c + 6);
    chk(evQ.size() == 0, "R2 all events seen", evQ.size(), 0);
    done = 1'b1;
    finishRun();
  end
endmodule